// File: doc/BRIEF.md
# SPI FIFO Data-Register Packing

This block sits between a 32-bit register bus and the two data FIFOs of an SPI master. A bus write to the transmit data register becomes one or two pushes into the transmit FIFO. A bus read of the receive data register becomes one or more pops from the receive FIFO. The number of words moved depends on the access mode, the configured data width (8 to 16 bits) and the byte enables. The shifter drains the transmit FIFO through a valid/ready pair. It fills the receive FIFO with words that carry a 4-bit peripheral chip-select tag.

Both FIFOs count their depth in data words, whatever the data width. Overflow and underflow are reported as sticky flags in a status register, next to each FIFO's level and its empty and full flags. Software clears a sticky flag by writing a one to its bit.

The bus side is run by a two-state machine. In ST_IDLE the block raises `bus_ready`. When `bus_valid` is seen, it takes the ACCEPT transition into ST_ACK. In that same clock edge it performs the FIFO action and registers the read data. ST_ACK raises `bus_rvalid` for one cycle and then takes the RETURN transition back to ST_IDLE.

Top module: `spi_fifo_regpack`

## Requirements
- R1: With `cfg_multi`=0, a write to the transmit register (address 0) pushes exactly one word: `bus_wdata[15:0]`, masked to the data width. The byte enables are ignored.
- R2: With `cfg_multi`=1, a transmit write pushes the low lane `bus_wdata[15:0]` if any of `bus_be[1:0]` is set. It then pushes the high lane `bus_wdata[31:16]` if any of `bus_be[3:2]` is set. The low lane goes first. The lanes stay 16 bits wide at every data width, and each word is masked to the data width.
- R3: A transmit write whose words do not all fit into the transmit FIFO is dropped as a whole and sets the sticky overrun flag (status bit 20). Writing 1 to bit 20 of the status register (address 2) clears the flag.
- R4: A read of the receive register (address 1) pops exactly one word if `cfg_tag_en`=1 or `cfg_multi`=0. With the tag enabled, the result is {12'b0, tag[3:0], data[15:0]}. Without the tag it is {16'b0, data}. The data is masked to the data width.
- R5: With `cfg_multi`=1 and `cfg_tag_en`=0, a receive read fills lanes in ascending order and pops one word per lane. At data width 8, each set bit of `bus_be` is an 8-bit lane. At wider data widths, each byte-enable pair with any bit set is a 16-bit lane.
- R6: A lane or single-word read that finds the receive FIFO empty returns zero in that field and sets the sticky underrun flag (status bit 21). Writing 1 to bit 21 clears the flag.
- R7: The status register reads {10'b0, underrun, overrun, rx_full, rx_empty, tx_full, tx_empty, rx_level[7:0], tx_level[7:0]}. After reset both levels are 0, both FIFOs are empty and both sticky flags are clear.
- R8: An access is accepted in a cycle where `bus_valid` and `bus_ready` are both high. In the next cycle `bus_rvalid` is high, `bus_rdata` is valid and `bus_ready` is low.
- R9: `tx_out_valid` is high whenever the transmit FIFO holds a word. `tx_out_data` shows the oldest word, and each cycle with `tx_out_ready` high pops one word, in push order.
- R10: `rx_in_ready` is low while the receive FIFO is full. A `rx_in_valid` cycle with `rx_in_ready` high stores `rx_in_data` together with `rx_in_tag`. A word offered while the FIFO is full is lost.
- R11: Each FIFO holds DEPTH words at any data width. It reports full only at DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_multi | input | 1 | 1 = multiple-word mode, 0 = one word per access |
| cfg_tag_en | input | 1 | Receive reads carry the chip-select tag |
| cfg_width | input | 5 | Data width in bits, 8 to 16 (clamped) |
| bus_valid | input | 1 | Bus access request |
| bus_ready | output | 1 | Block can accept an access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 transmit, 1 receive, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_rvalid | output | 1 | Response cycle of an accepted access |
| bus_rdata | output | 32 | Read data |
| tx_out_valid | output | 1 | Transmit FIFO holds a word |
| tx_out_ready | input | 1 | Shifter takes the head word |
| tx_out_data | output | 16 | Head word of the transmit FIFO |
| rx_in_valid | input | 1 | Shifter offers a received word |
| rx_in_ready | output | 1 | Receive FIFO has room |
| rx_in_data | input | 16 | Received word |
| rx_in_tag | input | 4 | Peripheral chip-select tag of the received word |

## Verification
The assertions check on every cycle the rules that hold regardless of data values. They cover the accept/response handshake, the stickiness of both error flags until a clearing write, and the levels never passing DEPTH. They also check that the transmit level rises only on an accepted transmit write and that shifter pushes and pops move each level by exactly one. Only the bench scenarios can show the content side: lane selection by byte enables, masking to the data width, the fixed 16-bit transmit lanes at width 8, the all-or-nothing drop of a two-word write, the tag placement and the zero-filled lanes of a short read.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam int LANE_W = 16;
    localparam int TAG_W  = 4;
    localparam int RXE_W  = LANE_W + TAG_W;

    typedef enum logic [1:0] {
        RG_TXDATA = 2'd0,
        RG_RXDATA = 2'd1,
        RG_STATUS = 2'd2,
        RG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;

    // Mask of the active data bits, width clamped to 8..16
    function automatic logic [LANE_W-1:0] width_mask(input logic [4:0] w);
        logic [4:0]  wc;
        logic [16:0] t;
        wc = (w < 5'd8) ? 5'd8 : ((w > 5'd16) ? 5'd16 : w);
        t  = (17'd1 << wc) - 17'd1;
        return t[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/rp_fifo.sv
module rp_fifo #(
    parameter  int DW    = 16,
    parameter  int DEPTH = 8,
    parameter  int NPUSH = 1,
    parameter  int NPOP  = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1,
    localparam int PW    = $clog2(NPUSH + 1),
    localparam int QW    = $clog2(NPOP + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PW-1:0]              push_n,
    input  logic [NPUSH-1:0][DW-1:0]   push_data,
    input  logic [QW-1:0]              pop_n,
    output logic [NPOP-1:0][DW-1:0]    peek_data,
    output logic [LVL_W-1:0]           level
);

    logic [DW-1:0]    mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [LVL_W-1:0] cnt;

    // Pointers and count; callers never exceed room or content
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            cnt    <= cnt + LVL_W'(push_n) - LVL_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NPUSH; k++) begin
            if (k < int'(push_n)) begin
                mem[wr_ptr + AW'(k)] <= push_data[k];
            end
        end
    end

    for (genvar g = 0; g < NPOP; g++) begin : g_peek
        assign peek_data[g] = mem[rd_ptr + AW'(g)];
    end

    assign level = cnt;

endmodule

// File: rtl/rp_tx_pack.sv
module rp_tx_pack
    import rp_pkg::*;
(
    input  logic                  multi,
    input  logic [4:0]            width,
    input  logic [31:0]           wdata,
    input  logic [3:0]            be,
    output logic [1:0][LANE_W-1:0] words,
    output logic [1:0]            n_words
);

    logic [LANE_W-1:0] m;
    logic              lane_lo;
    logic              lane_hi;

    assign m       = width_mask(width);
    assign lane_lo = multi ? (|be[1:0]) : 1'b1;
    assign lane_hi = multi & (|be[3:2]);

    always_comb begin
        words   = '0;
        n_words = 2'd0;
        if (lane_lo) begin
            words[0] = wdata[15:0] & m;
            n_words  = 2'd1;
        end
        if (lane_hi) begin
            if (lane_lo) begin
                words[1] = wdata[31:16] & m;
            end else begin
                words[0] = wdata[31:16] & m;
            end
            n_words = n_words + 2'd1;
        end
    end

endmodule

// File: rtl/rp_rx_unpack.sv
module rp_rx_unpack
    import rp_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic                   multi,
    input  logic                   tag_en,
    input  logic [4:0]             width,
    input  logic [3:0]             be,
    input  logic [3:0][RXE_W-1:0]  peek,
    input  logic [LVL_W-1:0]       avail,
    output logic [31:0]            rdata,
    output logic [2:0]             n_pop,
    output logic                   short_rd
);

    logic [LANE_W-1:0] m;
    logic              one_word;
    logic              byte_lanes;
    logic              unused_tags;

    assign m           = width_mask(width);
    assign one_word    = !multi || tag_en;
    assign byte_lanes  = (m == 16'h00FF);
    assign unused_tags = ^{peek[1][RXE_W-1:LANE_W], peek[2][RXE_W-1:LANE_W],
                           peek[3][RXE_W-1:LANE_W]};

    always_comb begin
        rdata    = '0;
        n_pop    = 3'd0;
        short_rd = 1'b0;
        if (one_word) begin
            if (avail != '0) begin
                rdata[15:0] = peek[0][LANE_W-1:0] & m;
                if (tag_en) begin
                    rdata[19:16] = peek[0][RXE_W-1:LANE_W];
                end
                n_pop = 3'd1;
            end else begin
                short_rd = 1'b1;
            end
        end else if (byte_lanes) begin
            for (int l = 0; l < 4; l++) begin
                if (be[l]) begin
                    if (int'(n_pop) < int'(avail)) begin
                        rdata[8*l +: 8] = peek[n_pop[1:0]][7:0];
                        n_pop = n_pop + 3'd1;
                    end else begin
                        short_rd = 1'b1;
                    end
                end
            end
        end else begin
            for (int l = 0; l < 2; l++) begin
                if (|be[2*l +: 2]) begin
                    if (int'(n_pop) < int'(avail)) begin
                        rdata[16*l +: 16] = peek[n_pop[1:0]][LANE_W-1:0] & m;
                        n_pop = n_pop + 3'd1;
                    end else begin
                        short_rd = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_fifo_regpack.sv
module spi_fifo_regpack
    import rp_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_multi,
    input  logic        cfg_tag_en,
    input  logic [4:0]  cfg_width,
    input  logic        bus_valid,
    output logic        bus_ready,
    input  logic        bus_write,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_be,
    output logic        bus_rvalid,
    output logic [31:0] bus_rdata,
    output logic        tx_out_valid,
    input  logic        tx_out_ready,
    output logic [15:0] tx_out_data,
    input  logic        rx_in_valid,
    output logic        rx_in_ready,
    input  logic [15:0] rx_in_data,
    input  logic [3:0]  rx_in_tag
);

    bus_state_e state_q, state_d;
    reg_sel_e   sel;
    logic       accept;
    logic       tx_wr, rx_rd, st_wr;

    logic [1:0][LANE_W-1:0]  tx_words;
    logic [1:0]              tx_n;
    logic [1:0]              tx_push_n;
    logic                    tx_pop_n;
    logic [0:0][LANE_W-1:0]  tx_peek;
    logic [LVL_W-1:0]        tx_level;
    logic                    tx_fits;

    logic [0:0][RXE_W-1:0]   rx_push_word;
    logic                    rx_push_n;
    logic [2:0]              rx_pop_n;
    logic [3:0][RXE_W-1:0]   rx_peek;
    logic [LVL_W-1:0]        rx_level;
    logic [31:0]             rd_word;
    logic [2:0]              rd_n;
    logic                    rd_short;

    logic        ovr_q, und_q;
    logic [31:0] status;
    logic [31:0] rd_mux;

    // Decode of the access taken this cycle
    assign sel    = reg_sel_e'(bus_addr);
    assign accept = bus_valid && (state_q == ST_IDLE);
    assign tx_wr  = accept && bus_write  && (sel == RG_TXDATA);
    assign rx_rd  = accept && !bus_write && (sel == RG_RXDATA);
    assign st_wr  = accept && bus_write  && (sel == RG_STATUS);

    // Transmit path
    rp_tx_pack u_pack (
        .multi   (cfg_multi),
        .width   (cfg_width),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .words   (tx_words),
        .n_words (tx_n)
    );

    assign tx_fits   = (int'(tx_n) + int'(tx_level)) <= DEPTH;
    assign tx_push_n = (tx_wr && tx_fits) ? tx_n : 2'd0;
    assign tx_pop_n  = tx_out_valid && tx_out_ready;

    rp_fifo #(.DW(LANE_W), .DEPTH(DEPTH), .NPUSH(2), .NPOP(1)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_words),
        .pop_n     (tx_pop_n),
        .peek_data (tx_peek),
        .level     (tx_level)
    );

    assign tx_out_valid = (tx_level != '0);
    assign tx_out_data  = tx_peek[0];

    // Receive path
    assign rx_in_ready     = (int'(rx_level) != DEPTH);
    assign rx_push_n       = rx_in_valid && rx_in_ready;
    assign rx_push_word[0] = {rx_in_tag, rx_in_data};

    rp_rx_unpack #(.LVL_W(LVL_W)) u_unpack (
        .multi    (cfg_multi),
        .tag_en   (cfg_tag_en),
        .width    (cfg_width),
        .be       (bus_be),
        .peek     (rx_peek),
        .avail    (rx_level),
        .rdata    (rd_word),
        .n_pop    (rd_n),
        .short_rd (rd_short)
    );

    assign rx_pop_n = rx_rd ? rd_n : 3'd0;

    rp_fifo #(.DW(RXE_W), .DEPTH(DEPTH), .NPUSH(1), .NPOP(4)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data (rx_push_word),
        .pop_n     (rx_pop_n),
        .peek_data (rx_peek),
        .level     (rx_level)
    );

    // Sticky error flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else begin
            if (tx_wr && !tx_fits) begin
                ovr_q <= 1'b1;
            end else if (st_wr && bus_wdata[20]) begin
                ovr_q <= 1'b0;
            end
            if (rx_rd && rd_short) begin
                und_q <= 1'b1;
            end else if (st_wr && bus_wdata[21]) begin
                und_q <= 1'b0;
            end
        end
    end

    assign status = {10'b0, und_q, ovr_q,
                     !rx_in_ready, (rx_level == '0),
                     (int'(tx_level) == DEPTH), !tx_out_valid,
                     8'(rx_level), 8'(tx_level)};

    always_comb begin
        unique case (sel)
            RG_RXDATA: rd_mux = bus_write ? 32'd0 : rd_word;
            RG_STATUS: rd_mux = bus_write ? 32'd0 : status;
            default:   rd_mux = 32'd0;
        endcase
    end

    // Bus state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_valid) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bus_rdata <= 32'd0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    // Bus state machine: outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin bus_ready = 1'b1; bus_rvalid = 1'b0; end
            ST_ACK:  begin bus_ready = 1'b0; bus_rvalid = 1'b1; end
            default: begin bus_ready = 1'b0; bus_rvalid = 1'b0; end
        endcase
    end

endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_ready,
    input logic             bus_rvalid,
    input logic             bus_write,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             tx_out_valid,
    input logic             tx_out_ready,
    input logic             rx_in_valid,
    input logic             rx_in_ready,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             ovr_q,
    input logic             und_q
);

    logic take, take_tx, take_rx, clr_ovr, clr_und;
    assign take    = bus_valid && bus_ready;
    assign take_tx = take && bus_write && (bus_addr == 2'd0);
    assign take_rx = take && !bus_write && (bus_addr == 2'd1);
    assign clr_ovr = take && bus_write && (bus_addr == 2'd2) && bus_wdata[20];
    assign clr_und = take && bus_write && (bus_addr == 2'd2) && bus_wdata[21];

    // R8
    handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (bus_rvalid && !bus_ready));

    // R1
    tx_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_tx |=> (tx_level <= $past(tx_level)));

    // R9
    tx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && tx_out_ready && !take_tx) |=>
        (tx_level == $past(tx_level) - LVL_W'(1)));

    // R10
    rx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && rx_in_ready && !take_rx) |=>
        (rx_level == $past(rx_level) + LVL_W'(1)));

    // R3
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_ovr) |=> ovr_q);

    // R6
    und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (und_q && !clr_und) |=> und_q);

    // R11
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

endmodule

bind spi_fifo_regpack rp_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_ready    (bus_ready),
    .bus_rvalid   (bus_rvalid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .rx_in_valid  (rx_in_valid),
    .rx_in_ready  (rx_in_ready),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .ovr_q        (ovr_q),
    .und_q        (und_q)
);

// File: tb/tb_spi_fifo_regpack.sv
module tb_spi_fifo_regpack;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_multi = 1'b0, cfg_tag_en = 1'b0;
    logic [4:0]  cfg_width = 5'd8;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [3:0]  bus_be = 4'hF;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic        tx_out_valid, tx_out_ready = 1'b0;
    logic [15:0] tx_out_data;
    logic        rx_in_valid = 1'b0, rx_in_ready;
    logic [15:0] rx_in_data = 16'd0;
    logic [3:0]  rx_in_tag = 4'd0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] rd_exp_q[$];
    logic        rd_chk_q[$];
    string       rd_req_q[$];
    logic [15:0] tx_exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    spi_fifo_regpack #(.DEPTH(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_multi(cfg_multi), .cfg_tag_en(cfg_tag_en), .cfg_width(cfg_width),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
        .rx_in_data(rx_in_data), .rx_in_tag(rx_in_tag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one bus access, expected response queued for the monitor
    task automatic bus_op(input logic wr, input logic [1:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, input logic do_chk,
                          input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_wdata = wd; bus_be = be;
        rd_exp_q.push_back(exp); rd_chk_q.push_back(do_chk); rd_req_q.push_back(req);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic tx_write(input logic [31:0] wd, input logic [3:0] be);
        bus_op(1'b1, 2'd0, wd, be, 1'b0, 32'd0, "");
    endtask

    task automatic rd_rx(input logic [3:0] be, input logic [31:0] exp, input string req);
        bus_op(1'b0, 2'd1, 32'd0, be, 1'b1, exp, req);
    endtask

    task automatic rd_st(input logic [31:0] exp, input string req);
        bus_op(1'b0, 2'd2, 32'd0, 4'hF, 1'b1, exp, req);
    endtask

    task automatic clr_flags(input logic [31:0] bits);
        bus_op(1'b1, 2'd2, bits, 4'hF, 1'b0, 32'd0, "");
    endtask

    task automatic inject(input logic [15:0] d, input logic [3:0] t);
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_data = d; rx_in_tag = t;
        @(posedge clk);
        #1 rx_in_valid = 1'b0;
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9 tx_out_valid", {31'd0, tx_out_valid}, 32'd1);
            chk("R9 tx_out_data order", {16'd0, tx_out_data}, {16'd0, tx_exp_q.pop_front()});
            tx_out_ready = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        tx_out_ready = 1'b0;
    endtask

    // Monitor: compare each response with the scoreboard head
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (rd_exp_q.size() == 0) begin
                chk("R8 unexpected response", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                logic        c;
                string       r;
                e = rd_exp_q.pop_front(); c = rd_chk_q.pop_front(); r = rd_req_q.pop_front();
                if (c) chk(r, bus_rdata, e);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_tests++; n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 ready after reset", {31'd0, bus_ready}, 32'd1);
        chk("R9 no tx word after reset", {31'd0, tx_out_valid}, 32'd0);
        chk("R10 rx ready after reset", {31'd0, rx_in_ready}, 32'd1);
        rd_st(32'h0005_0000, "R7 reset status");

        // Transmit packing
        cfg_width = 5'd8; cfg_multi = 1'b0;
        tx_write(32'hABCD_1234, 4'hF); tx_exp_q.push_back(16'h0034);          // R1
        cfg_multi = 1'b1;
        tx_write(32'h5678_9ABC, 4'hF); tx_exp_q.push_back(16'h00BC);          // R2
        tx_exp_q.push_back(16'h0078);
        tx_write(32'h0123_4567, 4'hC); tx_exp_q.push_back(16'h0023);          // R2 high lane only
        cfg_width = 5'd12;
        tx_write(32'hFFFF_0ABC, 4'hF); tx_exp_q.push_back(16'h0ABC);
        tx_exp_q.push_back(16'h0FFF);
        cfg_width = 5'd16;
        tx_write(32'h0000_CAFE, 4'h3); tx_exp_q.push_back(16'hCAFE);
        rd_st(32'h0004_0007, "R2 tx level after lane pushes");
        tx_write(32'h1111_2222, 4'hF);                                        // R3 dropped whole
        rd_st(32'h0014_0007, "R3 two-word write dropped, overrun set");
        cfg_multi = 1'b0; cfg_width = 5'd8;
        tx_write(32'h0000_00A5, 4'hF); tx_exp_q.push_back(16'h00A5);
        rd_st(32'h0016_0008, "R11 full at depth words");
        tx_write(32'h0000_0077, 4'hF);
        clr_flags(32'h0010_0000);
        rd_st(32'h0006_0008, "R3 overrun cleared, level kept");
        drain(8);
        chk("R9 tx empty after drain", {31'd0, tx_out_valid}, 32'd0);

        // Receive: tagged and single-word reads
        cfg_width = 5'd16; cfg_tag_en = 1'b1; cfg_multi = 1'b0;
        inject(16'hBEEF, 4'h5);
        rd_rx(4'hF, 32'h0005_BEEF, "R4 tagged single read");
        cfg_multi = 1'b1;
        inject(16'h1234, 4'h3);
        inject(16'h4321, 4'hC);
        rd_rx(4'hF, 32'h0003_1234, "R4 tag limits read to one word");
        rd_st(32'h0001_0100, "R4 one word left");
        rd_rx(4'hF, 32'h000C_4321, "R4 second tagged word");

        // Receive: multiple-word lanes
        cfg_tag_en = 1'b0; cfg_width = 5'd8;
        inject(16'h0011, 4'h0); inject(16'h0022, 4'h0); inject(16'h0033, 4'h0);
        rd_rx(4'hF, 32'h0033_2211, "R6 short byte-lane read zero-filled");
        rd_st(32'h0025_0000, "R6 underrun set");
        clr_flags(32'h0020_0000);
        cfg_width = 5'd16;
        inject(16'h1234, 4'h0); inject(16'h5678, 4'h0);
        rd_rx(4'hF, 32'h5678_1234, "R5 two 16-bit lanes");
        cfg_width = 5'd8;
        inject(16'hAB44, 4'h0);
        rd_rx(4'h4, 32'h0044_0000, "R5 single byte lane 2");
        cfg_width = 5'd12; cfg_multi = 1'b0;
        inject(16'hF123, 4'h9);
        rd_rx(4'hF, 32'h0000_0123, "R4 untagged single read masked");
        rd_st(32'h0005_0000, "R5 no underrun on full lanes");

        rd_rx(4'hF, 32'h0000_0000, "R6 empty single read returns zero");
        rd_st(32'h0025_0000, "R6 underrun on empty read");
        clr_flags(32'h0020_0000);

        // Receive FIFO full
        cfg_width = 5'd16;
        for (int i = 0; i < 8; i++) inject(16'(i), 4'h0);
        @(negedge clk);
        chk("R10 rx_in_ready low when full", {31'd0, rx_in_ready}, 32'd0);
        rd_st(32'h0009_0800, "R11 rx full at depth");
        inject(16'hDEAD, 4'h1);
        cfg_multi = 1'b1;
        rd_rx(4'hF, 32'h0001_0000, "R10 order 0,1");
        rd_rx(4'hF, 32'h0003_0002, "R10 order 2,3");
        rd_rx(4'hF, 32'h0005_0004, "R10 order 4,5");
        rd_rx(4'hF, 32'h0007_0006, "R10 word offered when full lost");
        rd_st(32'h0005_0000, "R10 empty after reads");

        repeat (3) @(negedge clk);
        chk("R8 all responses seen", 32'(rd_exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule